// File: doc/BRIEF.md
# Last Branch Record Stack

This block keeps a small circular record of the most recent control transfers seen by a processor core, for use by a debug subsystem. Each record is a pair of linear addresses: where the transfer came from and where it went. The core presents a transfer event as a one-cycle strobe with a two-bit type and the two addresses. The block writes an entry for taken branches, interrupts and exceptions. Debug exceptions are never written.

Recording is governed by a control register that software writes. The register has a record-enable bit, a trace-message bit and a freeze-on-PMI bit. A debug exception clears the record-enable bit and leaves the trace-message bit and the stored entries alone. While the trace-message bit is set, entries keep being written even if record-enable is clear. When the freeze bit is set, a performance-monitor interrupt request (PMI) freezes the stack. It stays frozen until software next writes the control register.

Software reads one entry per request through an index. The read data appears one cycle after the request. A top-of-stack pointer tells software which entry is the newest. The debugger uses these values to walk backwards from a failure toward its cause.

Top module: `lbr_stack`

## Requirements
- R1: When control bit 0 (record enable) is set, an event of type 0 (taken branch), 1 (interrupt) or 2 (exception) is captured. The pointer `tos_o` advances by one, modulo the depth, on the next clock edge. The new entry holds that event's source and destination addresses at the new pointer value, so the pointer always names the newest entry.
- R2: An event of type 3 (debug exception) is never captured. The pointer and the entries are unchanged.
- R3: A debug exception clears control bit 0 on the next clock edge. It leaves control bit 6 (trace message) unchanged and leaves all stored entries intact.
- R4: When bit 0 is clear and bit 6 is set, events of types 0 to 2 are still captured. When both bits are clear, no event is captured.
- R5: The stack holds the four most recent captures. The fifth capture overwrites the entry that was written first.
- R6: A PMI request (`pmi_i`) while control bit 11 is set raises `frozen_o` on the next edge. It also blocks any capture in that cycle. A PMI request while bit 11 is clear has no effect.
- R7: While frozen, no entry is written and the pointer holds. Any control register write clears the frozen state on the next edge, and captures then resume.
- R8: A read request (`rd_en_i`) with index `rd_idx_i` presents that entry on `rd_src_o`/`rd_dst_o` after the next edge. If a capture writes that same entry in the same cycle, the read returns the contents from before the write.
- R9: After reset, all entries, the pointer, the control register, the frozen state and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Transfer event strobe |
| ev_type_i | input | 2 | Event type: 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| ev_src_i | input | ADDR_W | Source linear address |
| ev_dst_i | input | ADDR_W | Destination linear address |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control write data (bit 0 record, bit 6 trace, bit 11 freeze on PMI) |
| pmi_i | input | 1 | Performance-monitor interrupt request strobe |
| rd_en_i | input | 1 | Entry read request |
| rd_idx_i | input | PTR_W | Entry index to read |
| ctrl_o | output | 16 | Current control register value |
| tos_o | output | PTR_W | Index of the newest entry |
| frozen_o | output | 1 | Stack frozen by PMI |
| rd_src_o | output | ADDR_W | Read data, source address |
| rd_dst_o | output | ADDR_W | Read data, destination address |

## Verification
A wrong capture decision shows up at `tos_o` one cycle after the event strobe. This covers a captured debug exception, a missed trace-only capture, and a write while frozen. A corrupted entry appears only when software reads that index, one cycle after the read request. The bench therefore reads entries back after every scenario, including reads made in the same cycle as a write to the same entry. A wrong freeze or control update is visible on `frozen_o` or `ctrl_o` on the very next cycle.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int CTRL_W  = 16;
  localparam int REC_BIT = 0;
  localparam int TRC_BIT = 6;
  localparam int FRZ_BIT = 11;

  typedef enum logic [1:0] {
    EV_BRANCH = 2'd0,
    EV_INTR   = 2'd1,
    EV_EXC    = 2'd2,
    EV_DBG    = 2'd3
  } ev_type_e;
endpackage

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [1:0]        ev_type_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              pmi_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              frozen_o,
  output logic              capture_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              frozen_q, frozen_d;
  logic              is_dbg, freeze_hit, rec_on;

  always_comb begin
    is_dbg     = ev_valid_i && (ev_type_e'(ev_type_i) == EV_DBG);
    freeze_hit = pmi_i && ctrl_q[FRZ_BIT];
    rec_on     = ctrl_q[REC_BIT] || ctrl_q[TRC_BIT];
    // freeze takes effect in the requesting cycle
    capture_o  = ev_valid_i && !is_dbg && rec_on && !frozen_q && !freeze_hit;

    ctrl_d = ctrl_we_i ? ctrl_wdata_i : ctrl_q;
    if (is_dbg) ctrl_d[REC_BIT] = 1'b0;

    if (freeze_hit)     frozen_d = 1'b1;
    else if (ctrl_we_i) frozen_d = 1'b0;
    else                frozen_d = frozen_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      frozen_q <= frozen_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/lbr_ptr.sv
module lbr_ptr #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] tos_o,
  output logic [PTR_W-1:0] next_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] tos_q;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign next_o = tos_q + PTR_W'(1);
    end else begin : g_wrap
      assign next_o = (tos_q == LAST) ? '0 : tos_q + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tos_q <= '0;
    else if (adv_i) tos_q <= next_o;
  end

  assign tos_o = tos_q;
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [ADDR_W-1:0] wsrc_i,
  input  logic [ADDR_W-1:0] wdst_i,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_dst_o
);
  logic [ADDR_W-1:0] src_q [DEPTH];
  logic [ADDR_W-1:0] dst_q [DEPTH];
  logic [DEPTH-1:0]  wsel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wsel[g] = we_i && (waddr_i == PTR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wsel[i]) begin
          src_q[i] <= wsrc_i;
          dst_q[i] <= wdst_i;
        end
      end
    end
  end

  // read samples pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_src_o <= '0;
      rd_dst_o <= '0;
    end else if (rd_en_i) begin
      rd_src_o <= src_q[rd_idx_i];
      rd_dst_o <= dst_q[rd_idx_i];
    end
  end
endmodule

// File: rtl/lbr_stack.sv
module lbr_stack
  import lbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [1:0]        ev_type_i,
  input  logic [ADDR_W-1:0] ev_src_i,
  input  logic [ADDR_W-1:0] ev_dst_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              pmi_i,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PTR_W-1:0]  tos_o,
  output logic              frozen_o,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_dst_o
);
  logic             capture;
  logic [PTR_W-1:0] wptr;

  lbr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_valid_i  (ev_valid_i),
    .ev_type_i   (ev_type_i),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .pmi_i       (pmi_i),
    .ctrl_o      (ctrl_o),
    .frozen_o    (frozen_o),
    .capture_o   (capture)
  );

  lbr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (capture),
    .tos_o (tos_o),
    .next_o(wptr)
  );

  lbr_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (capture),
    .waddr_i (wptr),
    .wsrc_i  (ev_src_i),
    .wdst_i  (ev_dst_i),
    .rd_en_i (rd_en_i),
    .rd_idx_i(rd_idx_i),
    .rd_src_o(rd_src_o),
    .rd_dst_o(rd_dst_o)
  );
endmodule

// File: rtl/lbr_stack_chk.sv
module lbr_stack_chk
  import lbr_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_valid_i,
  input logic [1:0]        ev_type_i,
  input logic              ctrl_we_i,
  input logic              pmi_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [PTR_W-1:0]  tos_o,
  input logic              frozen_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic dbg_ev;
  assign dbg_ev = ev_valid_i && (ev_type_i == 2'd3);

  a_r1_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tos_o == $past(tos_o)) ||
             (tos_o == (($past(tos_o) == LAST) ? '0 : $past(tos_o) + PTR_W'(1))));

  a_r2_dbg_not_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_ev |=> $stable(tos_o));

  a_r3_dbg_clears_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_ev |=> !ctrl_o[REC_BIT]);

  a_r3_dbg_keeps_trc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ev && !ctrl_we_i) |=> $stable(ctrl_o[TRC_BIT]));

  a_r4_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[REC_BIT] && !ctrl_o[TRC_BIT]) |=> $stable(tos_o));

  a_r6_pmi_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmi_i && ctrl_o[FRZ_BIT]) |=> frozen_o && $stable(tos_o));

  a_r7_frozen_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |=> $stable(tos_o));

  a_r7_frozen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !ctrl_we_i) |=> frozen_o);
endmodule

bind lbr_stack lbr_stack_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/lbr_stack_test.sv
`timescale 1ns/1ps
module lbr_stack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_v = 1'b0;
  logic [1:0]  ev_t = 2'd0;
  logic [31:0] ev_s = '0, ev_d = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic        pmi = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_idx = 2'd0;
  logic [15:0] ctrl;
  logic [1:0]  tos;
  logic        frozen;
  logic [31:0] rd_s, rd_d;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lbr_stack uut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_v), .ev_type_i(ev_t),
    .ev_src_i(ev_s), .ev_dst_i(ev_d), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .pmi_i(pmi), .rd_en_i(rd_en), .rd_idx_i(rd_idx), .ctrl_o(ctrl),
    .tos_o(tos), .frozen_o(frozen), .rd_src_o(rd_s), .rd_dst_o(rd_d)
  );

  // behavioural reference
  logic [31:0] m_src [4], m_dst [4];
  int          m_tos;
  logic [15:0] m_ctrl;
  bit          m_frz;
  logic [31:0] m_rs, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_src[i]) begin m_src[i] = 0; m_dst[i] = 0; end
      m_tos = 0; m_ctrl = 0; m_frz = 0; m_rs = 0; m_rd = 0;
    end else begin
      bit frz_hit, cap, dbg;
      logic [15:0] nc;
      dbg     = ev_v && ev_t == 2'd3;
      frz_hit = pmi && m_ctrl[11];
      cap     = ev_v && !dbg && (m_ctrl[0] || m_ctrl[6]) && !m_frz && !frz_hit;
      if (rd_en) begin m_rs = m_src[rd_idx]; m_rd = m_dst[rd_idx]; end
      if (cap) begin
        m_tos = (m_tos + 1) % 4;
        m_src[m_tos] = ev_s; m_dst[m_tos] = ev_d;
      end
      if (frz_hit) m_frz = 1; else if (we) m_frz = 0;
      nc = we ? wdata : m_ctrl;
      if (dbg) nc[0] = 1'b0;
      m_ctrl = nc;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model comparison on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 model tos", 32'(tos), 32'(m_tos));
      chk("R3 model ctrl", 32'(ctrl), 32'(m_ctrl));
      chk("R6 model frozen", 32'(frozen), 32'(m_frz));
      chk("R8 model rd_src", rd_s, m_rs);
      chk("R8 model rd_dst", rd_d, m_rd);
    end
  end

  task automatic tick();
    @(negedge clk);
    ev_v = 0; we = 0; pmi = 0; rd_en = 0;
  endtask

  task automatic ev(logic [1:0] t, logic [31:0] s, logic [31:0] d);
    ev_v = 1; ev_t = t; ev_s = s; ev_d = d; tick();
  endtask

  task automatic wr(logic [15:0] v);
    we = 1; wdata = v; tick();
  endtask

  task automatic rd(logic [1:0] idx);
    rd_en = 1; rd_idx = idx; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 tos", 32'(tos), 0);
    chk("R9 ctrl", 32'(ctrl), 0);
    chk("R9 frozen", 32'(frozen), 0);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i));
      chk("R9 entry", rd_s | rd_d, 0);
    end
    // off: no capture
    ev(2'd0, 32'h10, 32'h20);
    chk("R4 off", 32'(tos), 0);
    // record enabled
    wr(16'h0001);
    ev(2'd0, 32'h100, 32'h200);
    ev(2'd1, 32'h101, 32'h201);
    ev(2'd2, 32'h102, 32'h202);
    chk("R1 tos", 32'(tos), 3);
    rd(2'd1);
    chk("R1 src", rd_s, 32'h100);
    chk("R1 dst", rd_d, 32'h200);
    // debug exception
    ev(2'd3, 32'h1DB, 32'h2DB);
    chk("R2 tos", 32'(tos), 3);
    chk("R3 rec cleared", 32'(ctrl[0]), 0);
    rd(2'd3);
    chk("R3 kept", rd_s, 32'h102);
    // trace only
    wr(16'h0040);
    ev(2'd0, 32'h300, 32'h400);
    ev(2'd1, 32'h301, 32'h401);
    ev(2'd2, 32'h302, 32'h402);
    chk("R4 trace tos", 32'(tos), 2);
    rd(2'd1);
    chk("R5 overwrite", rd_s, 32'h301);
    rd(2'd3);
    chk("R5 oldest", rd_s, 32'h102);
    ev(2'd3, 32'h0, 32'h0);
    chk("R3 trc kept", 32'(ctrl[6]), 1);
    // freeze
    wr(16'h0801);
    ev_v = 1; ev_t = 2'd0; ev_s = 32'hBAD0; ev_d = 32'hBAD1; pmi = 1; tick();
    chk("R6 frozen", 32'(frozen), 1);
    chk("R6 blocked", 32'(tos), 2);
    ev(2'd0, 32'hBAD2, 32'hBAD3);
    ev(2'd1, 32'hBAD4, 32'hBAD5);
    chk("R7 tos held", 32'(tos), 2);
    rd(2'd3);
    chk("R7 entry held", rd_s, 32'h102);
    wr(16'h0001);
    chk("R7 unfrozen", 32'(frozen), 0);
    ev(2'd0, 32'h500, 32'h600);
    chk("R7 resume", 32'(tos), 3);
    // PMI ignored when freeze bit clear
    pmi = 1; tick();
    chk("R6 pmi ignored", 32'(frozen), 0);
    // read and write same slot (next slot 0 holds 0x300)
    ev_v = 1; ev_t = 2'd2; ev_s = 32'h700; ev_d = 32'h800;
    rd_en = 1; rd_idx = 2'd0; tick();
    chk("R8 old src", rd_s, 32'h300);
    chk("R8 old dst", rd_d, 32'h400);
    rd(2'd0);
    chk("R8 new src", rd_s, 32'h700);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule